// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver

This block receives HDLC-style frames from a serial line, one bit on each rising edge of the receive clock. It hunts for the flag octet and removes the zeros that a transmitter inserts after five ones. Characters are assembled least significant bit first. The block can drop frames that are addressed to another secondary station, and it checks the frame check sequence with CRC-CCITT.

The first character of a frame is the station address and the second is the control field. Both are always 8 bits long. Information characters after them use a length that software can set between 1 and 8 bits. A new length is picked up only at a character boundary.

An 8-bit flag window feeds a 16-bit holding stage. When the closing flag fills the window, the holding stage contains exactly the received check sequence. That sequence is therefore never delivered as data. The end of a frame gives an end pulse together with the CRC verdict and the length of a short final character, if there is one.

Top module: `hdlc_frame_rx`

## Requirements
- R1: Every flag octet (0x7E) in the serial stream makes `flagDet` high for exactly one clock cycle, and no other bit pattern does so.
- R2: A 0 that follows five consecutive 1s inside a frame is removed before assembly, so payload containing runs of ones (for example 0xFF or 0x7E bytes) is delivered unchanged.
- R3: The 16 bits that come just before the closing flag (the check sequence) are never delivered on `charData`. A frame yields only its address, control and information characters.
- R4: When `secondaryMode` is 1 and the first character differs from `stationAddr`, that frame delivers no characters and no end pulse.
- R5: When the address is accepted (it matches `stationAddr` in secondary mode, or any address when `secondaryMode` is 0), it is delivered with `charStrobe`. In the same cycle `startOfMsg` is 1 and `addrValid` is 1. `addrValid` then stays high through the end pulse of that frame.
- R6: The second character is the 8-bit control field, and `startOfMsg` is 0 when it is delivered.
- R7: Information characters have the length given by `charLen` (values 1 to 7, and 0 meaning 8). The first received bit goes to `charData[0]` and the data is right-aligned, with the unused upper bits at 0.
- R8: A write to `charLen` does not change the character that is being assembled. It takes effect from the next character boundary onward.
- R9: When the closing flag arrives, `endOfMsg` pulses for one cycle. At the same time `crcErr` is 1 if and only if the CRC over the data plus the received check sequence fails. The CRC uses polynomial 0x1021, preset 0xFFFF, shifts bits in arrival order, and passes on remainder 0x1D0F.
- R10: If the final character is short, its bits are delivered with `charStrobe` in the same cycle as `endOfMsg`, and `residLen` gives its bit count. When the final character is full length, `residLen` is 0.
- R11: While `rxEn` is low the receiver is held in reset. From the next cycle `charStrobe`, `endOfMsg`, `addrValid` and `startOfMsg` are 0, and a partly received frame is discarded.
- R12: After `rstN` is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; the serial bit is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEn | input | 1 | Receiver enable; low holds all receiver state in reset |
| rxData | input | 1 | Serial receive data |
| secondaryMode | input | 1 | 1 turns on address filtering against `stationAddr` |
| stationAddr | input | 8 | Address of this station for secondary filtering |
| charLen | input | 3 | Information character length, with 0 meaning 8 bits |
| flagDet | output | 1 | One-cycle pulse for each flag detected |
| addrValid | output | 1 | The frame's address has been accepted |
| charStrobe | output | 1 | One-cycle pulse; `charData` holds a new character |
| charData | output | 8 | Delivered character, right-aligned, first bit in bit 0 |
| startOfMsg | output | 1 | High from address delivery until control delivery |
| endOfMsg | output | 1 | One-cycle pulse when the closing flag arrives |
| residLen | output | 3 | Bit count of a short final character, 0 if full |
| crcErr | output | 1 | CRC check failed on the most recent frame |

## Verification
The assertions check properties that must hold on every cycle. A flag pulse never lasts two cycles. A deleted stuffed zero never moves the holding stage. A rising `startOfMsg` always comes with a strobe that carries the programmed address when filtering is on. A residual length always comes with its character. A low enable clears the strobes and the frame flags on the following cycle. Other behaviour can only be shown by the bench's frames. This covers the bit-exact content of each character across stuffing, the hiding of the check sequence, filtering against a wrong address, the CRC verdict on a corrupted sequence, and a length change that waits for the next character boundary.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int CHAR_W = 8;
  localparam int IDX_W  = $clog2(CHAR_W);

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CTRL,
    PH_INFO
  } rxPhase_t;

  typedef struct packed {
    logic             inFrame;
    logic             asmClear;
    logic [IDX_W-1:0] asmIdx;
  } rxCtl_t;
endpackage

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter int          FLAG_W      = 8,
  parameter logic [7:0]  FLAG_PAT    = 8'h7E,
  parameter int          HOLD_W      = 16,
  parameter int          STUFF_RUN   = 5,
  parameter logic [15:0] CRC_POLY    = 16'h1021,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'h1D0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxData,
  input  rxCtl_t            ctl,
  output logic              flagHit,
  output logic              popValid,
  output logic              holdFullNext,
  output logic              crcGood,
  output logic [CHAR_W-1:0] asmCur
);
  localparam int CNT_W   = $clog2(HOLD_W + 1);
  localparam int RUN_MAX = STUFF_RUN + 2;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [FLAG_W-1:0] win, vld, winNext;
  logic              exitBit, exitV, stuffed, pushEn, holdFull;
  logic [RUN_W-1:0]  ones;
  logic [HOLD_W-1:0] hold, crc, crcNext;
  logic [CNT_W-1:0]  holdCnt;
  logic [CHAR_W-1:0] asmReg;

  function automatic logic [HOLD_W-1:0] crcStep(input logic [HOLD_W-1:0] c, input logic b);
    logic fb;
    fb = c[HOLD_W-1] ^ b;
    return {c[HOLD_W-2:0], 1'b0} ^ (fb ? CRC_POLY[HOLD_W-1:0] : '0);
  endfunction

  // Flag window: raw bits, oldest bit leaves from the top.
  assign winNext = {win[FLAG_W-2:0], rxData};
  assign flagHit = (winNext == FLAG_PAT[FLAG_W-1:0]);
  assign exitBit = win[FLAG_W-1];
  assign exitV   = vld[FLAG_W-1];

  // Zero deletion on the stream leaving the window.
  assign stuffed  = exitV && !exitBit && (ones == RUN_W'(STUFF_RUN));
  assign pushEn   = exitV && ctl.inFrame && !stuffed;
  assign holdFull = (holdCnt == CNT_W'(HOLD_W));
  assign popValid = pushEn && holdFull;
  assign holdFullNext = holdFull || (pushEn && holdCnt == CNT_W'(HOLD_W - 1));

  assign crcNext = pushEn ? crcStep(crc, exitBit) : crc;
  assign crcGood = (crcNext == CRC_RESIDUE[HOLD_W-1:0]);

  always_comb begin
    asmCur = asmReg;
    if (popValid) asmCur[ctl.asmIdx] = hold[HOLD_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win     <= '0;
      vld     <= '0;
      ones    <= '0;
      hold    <= '0;
      holdCnt <= '0;
      crc     <= CRC_INIT[HOLD_W-1:0];
      asmReg  <= '0;
    end else if (!rxEn) begin
      win     <= '0;
      vld     <= '0;
      ones    <= '0;
      hold    <= '0;
      holdCnt <= '0;
      crc     <= CRC_INIT[HOLD_W-1:0];
      asmReg  <= '0;
    end else begin
      win <= winNext;
      vld <= flagHit ? '0 : {vld[FLAG_W-2:0], 1'b1};
      if (flagHit) begin
        ones    <= '0;
        hold    <= '0;
        holdCnt <= '0;
        crc     <= CRC_INIT[HOLD_W-1:0];
        asmReg  <= '0;
      end else begin
        if (exitV) begin
          if (!exitBit) ones <= '0;
          else if (ones != RUN_W'(RUN_MAX)) ones <= ones + 1'b1;
        end
        if (pushEn) begin
          hold <= {hold[HOLD_W-2:0], exitBit};
          if (!holdFull) holdCnt <= holdCnt + 1'b1;
        end
        crc    <= crcNext;
        asmReg <= ctl.asmClear ? '0 : asmCur;
      end
    end
  end

  // R2
  stuff_drop_chk: assert property (@(posedge clk) disable iff (!rstN || !rxEn)
    (stuffed && ctl.inFrame && !flagHit) |=> (holdCnt == $past(holdCnt)) && (hold == $past(hold)));
endmodule

// File: rtl/hdlc_rx_control.sv
module hdlc_rx_control
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              secondaryMode,
  input  logic [CHAR_W-1:0] stationAddr,
  input  logic [IDX_W-1:0]  charLen,
  input  logic              flagHit,
  input  logic              popValid,
  input  logic              holdFullNext,
  input  logic              crcGood,
  input  logic [CHAR_W-1:0] asmCur,
  output rxCtl_t            ctl,
  output logic              flagDet,
  output logic              addrValid,
  output logic              charStrobe,
  output logic [CHAR_W-1:0] charData,
  output logic              startOfMsg,
  output logic              endOfMsg,
  output logic [IDX_W-1:0]  residLen,
  output logic              crcErr
);
  logic             inFrame;
  rxPhase_t         phase;
  logic [IDX_W-1:0] bitCnt;
  logic [IDX_W:0]   curLen, lenDec, target, cntNow;
  logic             charDone, closing;

  assign lenDec   = (charLen == '0) ? (IDX_W+1)'(CHAR_W) : {1'b0, charLen};
  assign target   = (phase == PH_INFO) ? curLen : (IDX_W+1)'(CHAR_W);
  assign cntNow   = {1'b0, bitCnt} + {{IDX_W{1'b0}}, popValid};
  assign charDone = inFrame && popValid && (cntNow == target);
  assign closing  = flagHit && inFrame && holdFullNext && (phase != PH_ADDR);

  assign ctl.inFrame  = inFrame;
  assign ctl.asmClear = flagHit || charDone;
  assign ctl.asmIdx   = bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0; phase <= PH_ADDR; bitCnt <= '0; curLen <= '0;
      flagDet <= 1'b0; addrValid <= 1'b0; charStrobe <= 1'b0; charData <= '0;
      startOfMsg <= 1'b0; endOfMsg <= 1'b0; residLen <= '0; crcErr <= 1'b0;
    end else if (!rxEn) begin
      inFrame <= 1'b0; phase <= PH_ADDR; bitCnt <= '0; curLen <= '0;
      flagDet <= 1'b0; addrValid <= 1'b0; charStrobe <= 1'b0; charData <= '0;
      startOfMsg <= 1'b0; endOfMsg <= 1'b0; residLen <= '0; crcErr <= 1'b0;
    end else begin
      charStrobe <= 1'b0;
      endOfMsg   <= 1'b0;
      flagDet    <= flagHit;
      if (endOfMsg) begin
        addrValid  <= 1'b0;
        startOfMsg <= 1'b0;
      end
      if (flagHit) begin
        if (closing) begin
          endOfMsg <= 1'b0 | 1'b1;
          crcErr   <= !crcGood;
          residLen <= (cntNow == target) ? '0 : cntNow[IDX_W-1:0];
          if (cntNow != '0) begin
            charStrobe <= 1'b1;
            charData   <= asmCur;
            if (phase == PH_CTRL) startOfMsg <= 1'b0;
          end
        end else begin
          addrValid  <= 1'b0;
          startOfMsg <= 1'b0;
        end
        inFrame <= 1'b1;
        phase   <= PH_ADDR;
        bitCnt  <= '0;
        curLen  <= lenDec;
      end else if (inFrame && popValid) begin
        if (charDone) begin
          bitCnt <= '0;
          curLen <= lenDec;
          unique case (phase)
            PH_ADDR: begin
              if (secondaryMode && asmCur != stationAddr) begin
                inFrame <= 1'b0;
              end else begin
                charStrobe <= 1'b1;
                charData   <= asmCur;
                startOfMsg <= 1'b1;
                addrValid  <= 1'b1;
                phase      <= PH_CTRL;
              end
            end
            PH_CTRL: begin
              charStrobe <= 1'b1;
              charData   <= asmCur;
              startOfMsg <= 1'b0;
              phase      <= PH_INFO;
            end
            default: begin
              charStrobe <= 1'b1;
              charData   <= asmCur;
            end
          endcase
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R1
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagDet |=> !flagDet);

  // R5
  addr_accept_chk: assert property (@(posedge clk) disable iff (!rstN || !rxEn)
    $rose(startOfMsg) |-> (charStrobe && addrValid &&
                           (!$past(secondaryMode) || charData == $past(stationAddr))));

  // R10
  resid_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endOfMsg && residLen != '0) |-> charStrobe);

  // R11
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> (!charStrobe && !endOfMsg && !addrValid && !startOfMsg));
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int          FLAG_W      = 8,
  parameter logic [7:0]  FLAG_PAT    = 8'h7E,
  parameter int          HOLD_W      = 16,
  parameter int          STUFF_RUN   = 5,
  parameter logic [15:0] CRC_POLY    = 16'h1021,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'h1D0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxData,
  input  logic              secondaryMode,
  input  logic [CHAR_W-1:0] stationAddr,
  input  logic [IDX_W-1:0]  charLen,
  output logic              flagDet,
  output logic              addrValid,
  output logic              charStrobe,
  output logic [CHAR_W-1:0] charData,
  output logic              startOfMsg,
  output logic              endOfMsg,
  output logic [IDX_W-1:0]  residLen,
  output logic              crcErr
);
  rxCtl_t            ctl;
  logic              flagHit, popValid, holdFullNext, crcGood;
  logic [CHAR_W-1:0] asmCur;

  hdlc_rx_datapath #(
    .FLAG_W(FLAG_W), .FLAG_PAT(FLAG_PAT), .HOLD_W(HOLD_W), .STUFF_RUN(STUFF_RUN),
    .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT), .CRC_RESIDUE(CRC_RESIDUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxData(rxData), .ctl(ctl),
    .flagHit(flagHit), .popValid(popValid), .holdFullNext(holdFullNext),
    .crcGood(crcGood), .asmCur(asmCur)
  );

  hdlc_rx_control u_ctl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .secondaryMode(secondaryMode),
    .stationAddr(stationAddr), .charLen(charLen), .flagHit(flagHit),
    .popValid(popValid), .holdFullNext(holdFullNext), .crcGood(crcGood),
    .asmCur(asmCur), .ctl(ctl), .flagDet(flagDet), .addrValid(addrValid),
    .charStrobe(charStrobe), .charData(charData), .startOfMsg(startOfMsg),
    .endOfMsg(endOfMsg), .residLen(residLen), .crcErr(crcErr)
  );
endmodule

// File: tb/hdlc_frame_rx_tb.sv
module hdlc_frame_rx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEn = 1'b0;
  logic       rxData = 1'b1;
  logic       secondaryMode = 1'b0;
  logic [7:0] stationAddr = 8'h00;
  logic [2:0] charLen = 3'd0;
  logic       flagDet, addrValid, charStrobe, startOfMsg, endOfMsg, crcErr;
  logic [7:0] charData;
  logic [2:0] residLen;

  always #2.5 clk = ~clk;

  hdlc_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxData(rxData),
    .secondaryMode(secondaryMode), .stationAddr(stationAddr), .charLen(charLen),
    .flagDet(flagDet), .addrValid(addrValid), .charStrobe(charStrobe),
    .charData(charData), .startOfMsg(startOfMsg), .endOfMsg(endOfMsg),
    .residLen(residLen), .crcErr(crcErr)
  );

  typedef struct { logic [7:0] d; bit sof; } item_t;
  typedef struct { bit err; logic [2:0] res; } eom_t;
  item_t      charQ[$];
  eom_t       eomQ[$];
  logic [7:0] infoBytes[$];
  int checks = 0, fails = 0, monChecks = 0, monFails = 0;
  int flagPulses = 0, flagsSent = 0, drvIdx = 0, switchAt = -1;
  logic [2:0] switchLen = 3'd0;
  item_t expItem;
  eom_t  expEom;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic monChk(input bit ok, input string req, input string what, input int act, input int exp);
    monChecks++;
    if (!ok) begin
      monFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items when the design produces results.
  always @(negedge clk) begin
    if (rstN) begin
      if (flagDet) flagPulses++;
      if (charStrobe) begin
        if (charQ.size() == 0) begin
          monChk(1'b0, "R3", "unexpected character", int'(charData), -1);
        end else begin
          expItem = charQ.pop_front();
          monChk(charData == expItem.d, "R7", "character data", int'(charData), int'(expItem.d));
          monChk(startOfMsg == expItem.sof, "R6", "startOfMsg at strobe", int'(startOfMsg), int'(expItem.sof));
          monChk(addrValid == 1'b1, "R5", "addrValid at strobe", int'(addrValid), 1);
        end
      end
      if (endOfMsg) begin
        if (eomQ.size() == 0) begin
          monChk(1'b0, "R4", "unexpected end of message", 1, 0);
        end else begin
          expEom = eomQ.pop_front();
          monChk(crcErr == expEom.err, "R9", "crcErr", int'(crcErr), int'(expEom.err));
          monChk(residLen == expEom.res, "R10", "residLen", int'(residLen), int'(expEom.res));
        end
      end
    end
  end

  task automatic sendBit(input bit b);
    @(negedge clk);
    if (charStrobe) begin
      if (drvIdx == switchAt) charLen = switchLen;
      drvIdx++;
    end
    rxData = b;
  endtask

  task automatic sendFlag();
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) sendBit(f[i]);
    flagsSent++;
  endtask

  function automatic int lenDec(input int x);
    return (x == 0) ? 8 : x;
  endfunction

  task automatic runFrame(input logic [7:0] addr, input logic [7:0] ctrl, input int infoBits,
                          input int initLen, input int swAt, input int swLen,
                          input bit accept, input bit corrupt);
    bit pay[$];
    logic [15:0] c, fcs;
    int pos, idx, len, n, ones;
    logic [7:0] d;
    item_t it;
    eom_t eo;
    bit fb, last;
    for (int i = 0; i < 8; i++) pay.push_back(addr[i]);
    for (int i = 0; i < 8; i++) pay.push_back(ctrl[i]);
    for (int j = 0; j < infoBits; j++) pay.push_back(infoBytes[j/8][j%8]);
    if (accept) begin
      it.d = addr; it.sof = 1'b1; charQ.push_back(it);
      it.d = ctrl; it.sof = 1'b0; charQ.push_back(it);
      pos = 16; idx = 2; last = 0; eo.res = 3'd0;
      while (pos < pay.size()) begin
        len = (swAt >= 0 && idx >= swAt + 2) ? lenDec(swLen) : lenDec(initLen);
        n = (pay.size() - pos < len) ? pay.size() - pos : len;
        d = 8'h00;
        for (int k = 0; k < n; k++) d[k] = pay[pos + k];
        it.d = d; it.sof = 1'b0; charQ.push_back(it);
        eo.res = (n < len) ? 3'(n) : 3'd0;
        pos += n; idx++;
      end
      eo.err = corrupt;
      eomQ.push_back(eo);
    end
    c = 16'hFFFF;
    foreach (pay[i]) begin
      fb = c[15] ^ pay[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    fcs = ~c;
    if (corrupt) fcs[3] = ~fcs[3];
    for (int k = 15; k >= 0; k--) pay.push_back(fcs[k]);
    charLen = 3'(initLen); switchAt = swAt; switchLen = 3'(swLen); drvIdx = 0;
    sendFlag();
    ones = 0;
    foreach (pay[i]) begin
      sendBit(pay[i]);
      if (pay[i]) begin
        ones++;
        if (ones == 5) begin sendBit(1'b0); ones = 0; end
      end else ones = 0;
    end
    sendFlag();
    sendFlag();
    repeat (3) @(negedge clk);
    // R3: nothing beyond the expected characters, the check field stays hidden
    chk(charQ.size() == 0, "R3", "characters left undelivered", charQ.size(), 0);
    chk(eomQ.size() == 0, "R9", "end pulses left undelivered", eomQ.size(), 0);
    switchAt = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + monChecks + 1, fails + monFails + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk({flagDet, addrValid, charStrobe, startOfMsg, endOfMsg, crcErr} == 6'b0, "R12", "control outputs in reset", 0, 0);
    chk(charData == 8'h00 && residLen == 3'd0, "R12", "data outputs in reset", int'(charData), 0);
    rstN = 1'b1;
    rxEn = 1'b1;
    for (int i = 0; i < 10; i++) sendBit(1'b1);

    // R2/R5/R6/R9: primary frame with long runs of ones in payload
    infoBytes = '{8'hFF, 8'h7E, 8'hF8, 8'h3F};
    runFrame(8'h35, 8'h10, 32, 0, -1, 0, 1'b1, 1'b0);
    chk(flagPulses == flagsSent, "R1", "flag pulse count", flagPulses, flagsSent);

    // R7/R10: 5-bit info characters with a 4-bit residual
    infoBytes = '{8'hC5, 8'h3A, 8'h96};
    runFrame(8'h81, 8'h22, 24, 5, -1, 0, 1'b1, 1'b0);

    // R8: secondary match, length switches from 8 to 3 after the boundary
    secondaryMode = 1'b1; stationAddr = 8'hA6;
    infoBytes = '{8'h5A, 8'hE1, 8'h0F, 8'h77, 8'h92};
    runFrame(8'hA6, 8'h4C, 40, 0, 2, 3, 1'b1, 1'b0);

    // R4: secondary mismatch delivers nothing
    infoBytes = '{8'h13, 8'h57};
    runFrame(8'hA7, 8'h01, 16, 0, -1, 0, 1'b0, 1'b0);
    chk(addrValid == 1'b0, "R4", "addrValid after rejected frame", int'(addrValid), 0);

    // R9: corrupted check sequence
    secondaryMode = 1'b0;
    infoBytes = '{8'h11, 8'h22, 8'h33};
    runFrame(8'h0C, 8'h03, 24, 0, -1, 0, 1'b1, 1'b1);
    chk(flagPulses == flagsSent, "R1", "flag pulse count", flagPulses, flagsSent);

    // R11: enable drop mid-frame discards the rest
    begin
      logic [7:0] abyte[6];
      abyte = '{8'h42, 8'h24, 8'h12, 8'h34, 8'h56, 8'h21};
      it_push(8'h42, 1'b1);
      it_push(8'h24, 1'b0);
      charLen = 3'd0;
      sendFlag();
      for (int j = 0; j < 42; j++) sendBit(abyte[j/8][j%8]);
      @(negedge clk);
      rxEn = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!addrValid && !startOfMsg && !charStrobe && !endOfMsg, "R11", "outputs after enable drop",
          int'({addrValid, startOfMsg, charStrobe, endOfMsg}), 0);
      chk(charQ.size() == 0, "R11", "characters before enable drop", charQ.size(), 0);
      for (int j = 0; j < 20; j++) sendBit(1'b1);
      rxEn = 1'b1;
      for (int j = 0; j < 4; j++) sendBit(1'b1);
    end
    infoBytes = '{8'h6D, 8'hB2};
    runFrame(8'h99, 8'h08, 16, 0, -1, 0, 1'b1, 1'b0);
    chk(flagPulses == flagsSent, "R1", "flag pulse count", flagPulses, flagsSent);

    $display("End of test - %0d assertions evaluated, %0d failures", checks + monChecks, fails + monFails);
    $finish;
  end

  task automatic it_push(input logic [7:0] d, input bit sof);
    item_t it;
    it.d = d; it.sof = sof;
    charQ.push_back(it);
  endtask
endmodule